// File: doc/BRIEF.md
# Direct-Mapped Read Cache

This block sits between a processor load port and a slower memory that returns one word at a time. It holds a parameterised number of lines, each a power-of-two number of bytes. A byte address is cut into three fields. The low offset picks a byte within a line, the index above it picks exactly one line, and the tag above that names which memory block occupies the line. Each line keeps a valid flag and a stored tag. After reset every line is invalid.

A load is handed over with a valid/ready handshake. The cache takes a new load only while it is idle, and it stalls the processor until the load completes. A hit costs a fixed lookup delay followed by a fixed per-word data delay. On a miss the indexed line is invalidated and one burst request is sent with the line-aligned address. The words that come back are written into the line in ascending order. Once the last word has arrived the line is marked valid with the new tag, and the requested word is delivered after the data delay. Two counters report how many lookups hit and how many missed.

Top module: `dm_read_cache`

## Requirements
- R1: With OFF_W = log2(LINE_BYTES), IDX_W = log2(LINES) and WOFF_W = log2(WORD_BYTES), the index is address bits [OFF_W+IDX_W-1:OFF_W], the tag is the bits above the index, and the response carries the WORD_BYTES-aligned word that contains the requested byte address.
- R2: A lookup hits exactly when the indexed line is valid and its stored tag equals the address tag, so a repeated access to a line that is still resident hits.
- R3: While reset is applied, rsp_valid and mem_req are 0 and both counters read 0. After reset every line is invalid, so the first reference to any line misses.
- R4: For a hit, rsp_valid is high for exactly one cycle, LOOKUP_CYC+WORD_CYC clock edges after the edge that accepted the request.
- R5: For a miss, mem_req is high for exactly one cycle, LOOKUP_CYC edges after the accepting edge, and mem_addr then holds the request address with its low OFF_W bits cleared.
- R6: During a refill, every cycle with mem_rvalid high supplies the next word of the line, in ascending word order starting at the line base. The response follows WORD_CYC edges after the edge that samples the last word, and the refilled line then hits.
- R7: req_ready is high only while idle. It is low from the accepting edge up to and including the response cycle, and a request held valid during that time is taken only at the first edge at which req_ready is high.
- R8: hit_count or miss_count increases by one at the lookup decision, LOOKUP_CYC edges after acceptance. Exactly one of the two counters moves for each request.
- R9: With a 5-bit address and four 2-byte lines, loads to 1, 13, 0, 6, 5, 6, 10, 12 from reset give 2 hits and 6 misses.
- R10: A miss replaces the indexed line, so alternating loads to two addresses that share an index but differ in tag all miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Load request present |
| req_addr | input | ADDR_W | Byte address of the load |
| req_ready | output | 1 | Cache idle and able to take a load |
| rsp_valid | output | 1 | One-cycle strobe that the load data is available |
| rsp_data | output | WORD_BYTES*8 | Word containing the requested byte |
| mem_req | output | 1 | One-cycle burst request to memory |
| mem_addr | output | ADDR_W | Line-aligned base address of the burst |
| mem_rvalid | input | 1 | One returned word is present |
| mem_rdata | input | WORD_BYTES*8 | Returned word |
| hit_count | output | CNT_W | Number of lookups that hit |
| miss_count | output | CNT_W | Number of lookups that missed |

## Verification
The hardest situation to reach from the ports is a request that is already waiting while the previous load is still in its lookup or in a long refill. A faulty ready or acceptance condition shows up only in that overlap. The bench raises the next request in the cycle right after each acceptance, so every load after the first is held against a busy controller. The bench's reference model predicts the exact acceptance edge, the response edge, the burst edge and the counter steps, and compares them on every clock. Conflict eviction is driven by alternating tags on one index, and the offset and index fields are exercised by a sequential sweep in which each line sees one miss and then one hit.

// File: rtl/dm_read_cache_pkg.sv
package dm_read_cache_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_REQ,
    ST_FILL,
    ST_DATA,
    ST_RESP
  } cache_st_e;

endpackage

// File: rtl/dm_rc_tag_store.sv
module dm_rc_tag_store #(
  parameter int LINES = 512,
  parameter int IDX_W = 9,
  parameter int TAG_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] rd_tag,
  input  logic             inv_en,
  input  logic             wr_en,
  output logic             hit
);

  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] valid_d;
  logic [TAG_W-1:0] tag_q [LINES];

  always_comb begin
    valid_d = valid_q;
    if (inv_en) valid_d[rd_idx] = 1'b0;
    if (wr_en)  valid_d[rd_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else if (inv_en || wr_en) valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[rd_idx] <= rd_tag;
  end

  assign hit = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);

  // R6
  install_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> hit);

  // R10
  evict_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_en |=> !hit);

endmodule

// File: rtl/dm_rc_line_store.sv
module dm_rc_line_store #(
  parameter int LINES  = 512,
  parameter int IDX_W  = 9,
  parameter int WPL    = 16,
  parameter int WSEL_W = 4,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  idx,
  input  logic              wr_en,
  input  logic [WSEL_W-1:0] wr_sel,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [WSEL_W-1:0] rd_sel,
  output logic [WORD_W-1:0] rd_word
);

  logic [WPL-1:0][WORD_W-1:0] line_q [LINES];

  always_ff @(posedge clk) begin
    if (wr_en) line_q[idx][wr_sel] <= wr_word;
  end

  assign rd_word = line_q[idx][rd_sel];

endmodule

// File: rtl/dm_rc_ctrl.sv
module dm_rc_ctrl
  import dm_read_cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 9,
  parameter int OFF_W      = 6,
  parameter int WOFF_W     = 2,
  parameter int WSEL_W     = 4,
  parameter int TAG_W      = 17,
  parameter int WORD_W     = 32,
  parameter int LOOKUP_CYC = 2,
  parameter int WORD_CYC   = 3,
  parameter int CNT_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              tag_hit,
  output logic [IDX_W-1:0]  look_idx,
  output logic [TAG_W-1:0]  look_tag,
  input  logic [WORD_W-1:0] rd_word,
  output logic [WSEL_W-1:0] rd_sel,
  output logic              inv_en,
  output logic              tag_wr_en,
  output logic              line_wr_en,
  output logic [WSEL_W-1:0] line_wr_sel,
  output logic [WORD_W-1:0] line_wr_word,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);

  localparam int MAX_DLY = (LOOKUP_CYC > WORD_CYC) ? LOOKUP_CYC : WORD_CYC;
  localparam int DLY_W   = $clog2(MAX_DLY + 1);
  localparam logic [DLY_W-1:0]  LOOK_LOAD = DLY_W'(LOOKUP_CYC - 1);
  localparam logic [DLY_W-1:0]  DATA_LOAD = DLY_W'(WORD_CYC - 1);
  localparam logic [WSEL_W-1:0] LAST_WORD = '1;

  cache_st_e          state_q, state_d;
  logic [ADDR_W-1:0]  addr_q;
  logic               addr_en;
  logic [DLY_W-1:0]   dly_q, dly_d;
  logic               dly_en;
  logic [WSEL_W-1:0]  fill_q, fill_d;
  logic               fill_en;
  logic [WORD_W-1:0]  rsp_q;
  logic               rsp_en;
  logic [CNT_W-1:0]   hitc_q, missc_q;
  logic               hit_inc, miss_inc;

  // next-state logic
  always_comb begin
    state_d    = state_q;
    addr_en    = 1'b0;
    dly_d      = dly_q;
    dly_en     = 1'b0;
    fill_d     = fill_q;
    fill_en    = 1'b0;
    rsp_en     = 1'b0;
    hit_inc    = 1'b0;
    miss_inc   = 1'b0;
    inv_en     = 1'b0;
    tag_wr_en  = 1'b0;
    line_wr_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid && rst_n) begin
          addr_en = 1'b1;
          dly_d   = LOOK_LOAD;
          dly_en  = 1'b1;
          state_d = ST_LOOK;
        end
      end
      ST_LOOK: begin
        if (dly_q == '0) begin
          if (tag_hit) begin
            hit_inc = 1'b1;
            dly_d   = DATA_LOAD;
            dly_en  = 1'b1;
            state_d = ST_DATA;
          end else begin
            miss_inc = 1'b1;
            inv_en   = 1'b1;
            state_d  = ST_REQ;
          end
        end else begin
          dly_d  = dly_q - DLY_W'(1);
          dly_en = 1'b1;
        end
      end
      ST_REQ: begin
        fill_d  = '0;
        fill_en = 1'b1;
        state_d = ST_FILL;
      end
      ST_FILL: begin
        if (mem_rvalid) begin
          line_wr_en = 1'b1;
          if (fill_q == LAST_WORD) begin
            tag_wr_en = 1'b1;
            dly_d     = DATA_LOAD;
            dly_en    = 1'b1;
            state_d   = ST_DATA;
          end else begin
            fill_d  = fill_q + WSEL_W'(1);
            fill_en = 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (dly_q == '0) begin
          rsp_en  = 1'b1;
          state_d = ST_RESP;
        end else begin
          dly_d  = dly_q - DLY_W'(1);
          dly_en = 1'b1;
        end
      end
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dly_q   <= '0;
      fill_q  <= '0;
      hitc_q  <= '0;
      missc_q <= '0;
    end else begin
      state_q <= state_d;
      if (dly_en)   dly_q   <= dly_d;
      if (fill_en)  fill_q  <= fill_d;
      if (hit_inc)  hitc_q  <= hitc_q + CNT_W'(1);
      if (miss_inc) missc_q <= missc_q + CNT_W'(1);
    end
  end

  // datapath registers, no reset
  always_ff @(posedge clk) begin
    if (addr_en) addr_q <= req_addr;
    if (rsp_en)  rsp_q  <= rd_word;
  end

  generate
    if (WOFF_W > 0) begin : g_byte_lane
      logic unused_byte_lane;
      assign unused_byte_lane = ^addr_q[(WOFF_W > 0 ? WOFF_W-1 : 0):0];
    end
  endgenerate

  assign req_ready    = (state_q == ST_IDLE) && rst_n;
  assign rsp_valid    = (state_q == ST_RESP);
  assign rsp_data     = rsp_q;
  assign mem_req      = (state_q == ST_REQ);
  assign mem_addr     = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign look_idx     = addr_q[OFF_W+IDX_W-1:OFF_W];
  assign look_tag     = addr_q[ADDR_W-1:OFF_W+IDX_W];
  assign rd_sel       = addr_q[OFF_W-1:WOFF_W];
  assign line_wr_sel  = fill_q;
  assign line_wr_word = mem_rdata;
  assign hit_count    = hitc_q;
  assign miss_count   = missc_q;

  // R5
  burst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R7
  burst_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);

  // R4
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  // R8
  one_counter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_count != $past(hit_count)) |-> (miss_count == $past(miss_count)));

  // R2
  hit_from_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_count != $past(hit_count)) |-> $past(tag_hit));

  // R2
  miss_from_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_count != $past(miss_count)) |-> !$past(tag_hit));

endmodule

// File: rtl/dm_read_cache.sv
module dm_read_cache #(
  parameter int ADDR_W      = 32,
  parameter int LINES       = 512,
  parameter int LINE_BYTES  = 64,
  parameter int WORD_BYTES  = 4,
  parameter int LOOKUP_CYC  = 2,
  parameter int WORD_CYC    = 3,
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [ADDR_W-1:0]       req_addr,
  output logic                    req_ready,
  output logic                    rsp_valid,
  output logic [WORD_BYTES*8-1:0] rsp_data,
  output logic                    mem_req,
  output logic [ADDR_W-1:0]       mem_addr,
  input  logic                    mem_rvalid,
  input  logic [WORD_BYTES*8-1:0] mem_rdata,
  output logic [CNT_W-1:0]        hit_count,
  output logic [CNT_W-1:0]        miss_count
);

  localparam int WORD_W = WORD_BYTES * 8;
  localparam int IDX_W  = $clog2(LINES);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int WOFF_W = $clog2(WORD_BYTES);
  localparam int WPL    = LINE_BYTES / WORD_BYTES;
  localparam int WSEL_W = OFF_W - WOFF_W;
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;

  // reset: asserted asynchronously, released on the clock
  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign core_rst_n = rst_pipe_q[SYNC_STAGES-1];

  logic              tag_hit;
  logic [IDX_W-1:0]  look_idx;
  logic [TAG_W-1:0]  look_tag;
  logic [WORD_W-1:0] rd_word;
  logic [WSEL_W-1:0] rd_sel;
  logic              inv_en;
  logic              tag_wr_en;
  logic              line_wr_en;
  logic [WSEL_W-1:0] line_wr_sel;
  logic [WORD_W-1:0] line_wr_word;

  dm_rc_ctrl #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .WOFF_W(WOFF_W),
    .WSEL_W(WSEL_W), .TAG_W(TAG_W), .WORD_W(WORD_W),
    .LOOKUP_CYC(LOOKUP_CYC), .WORD_CYC(WORD_CYC), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(core_rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .tag_hit(tag_hit), .look_idx(look_idx), .look_tag(look_tag),
    .rd_word(rd_word), .rd_sel(rd_sel),
    .inv_en(inv_en), .tag_wr_en(tag_wr_en),
    .line_wr_en(line_wr_en), .line_wr_sel(line_wr_sel), .line_wr_word(line_wr_word),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  dm_rc_tag_store #(
    .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_tags (
    .clk(clk), .rst_n(core_rst_n),
    .rd_idx(look_idx), .rd_tag(look_tag),
    .inv_en(inv_en), .wr_en(tag_wr_en), .hit(tag_hit)
  );

  dm_rc_line_store #(
    .LINES(LINES), .IDX_W(IDX_W), .WPL(WPL), .WSEL_W(WSEL_W), .WORD_W(WORD_W)
  ) u_lines (
    .clk(clk), .idx(look_idx),
    .wr_en(line_wr_en), .wr_sel(line_wr_sel), .wr_word(line_wr_word),
    .rd_sel(rd_sel), .rd_word(rd_word)
  );

  // R3
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    $rose(core_rst_n) |-> (hit_count == '0 && miss_count == '0));

endmodule

// File: tb/dm_read_cache_test.sv
`timescale 1ns/1ps
module dm_read_cache_test;

  localparam int AW = 5, NL = 4, LB = 2, WB = 1, LK = 2, WC = 3, CW = 16;
  localparam int WW = WB * 8, WPL = LB / WB;
  localparam int OFFB = $clog2(LB), IDXB = $clog2(NL);
  localparam int MEM_FIRST = 50, MEM_NEXT = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid;
  logic [AW-1:0] req_addr;
  logic req_ready, rsp_valid, mem_req, mem_rvalid;
  logic [WW-1:0] rsp_data, mem_rdata;
  logic [AW-1:0] mem_addr;
  logic [CW-1:0] hit_count, miss_count;

  always #4 clk = ~clk;

  dm_read_cache #(
    .ADDR_W(AW), .LINES(NL), .LINE_BYTES(LB), .WORD_BYTES(WB),
    .LOOKUP_CYC(LK), .WORD_CYC(WC), .CNT_W(CW)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .hit_count(hit_count), .miss_count(miss_count)
  );

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  task automatic check(input string tag, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int word_of(input int wa);
    return (wa * 37 + 11) & ((1 << WW) - 1);
  endfunction

  typedef struct {
    int n0;
    int cnt_at;
    bit hit;
    int mreq_at;
    int maddr;
    int resp_at;
    int data;
  } rec_t;

  rec_t recs[$];
  int   stim[$];
  int   st_time[$];
  int   st_addr[$];
  bit   mval[NL];
  int   mtag[NL];
  int   n = 0;
  int   exp_hits = 0, exp_misses = 0;
  int   last_resp = -10;
  int   present_n0 = 0;
  bit   presenting = 0;
  bit   running = 0;

  task automatic present(input int a);
    rec_t r;
    int idx, tg;
    idx = (a >> OFFB) % NL;
    tg  = a >> (OFFB + IDXB);
    r.n0 = ((n > last_resp + 1) ? n : last_resp + 1) + 1;
    r.cnt_at = r.n0 + LK;
    r.hit = mval[idx] && (mtag[idx] == tg);
    r.data = word_of(a / WB);
    if (r.hit) begin
      r.mreq_at = -1;
      r.maddr = 0;
      r.resp_at = r.n0 + LK + WC;
    end else begin
      mval[idx] = 1'b1;
      mtag[idx] = tg;
      r.mreq_at = r.n0 + LK;
      r.maddr = a - (a % LB);
      r.resp_at = r.mreq_at + MEM_FIRST + MEM_NEXT * (WPL - 1) + 1 + WC;
    end
    last_resp = r.resp_at;
    recs.push_back(r);
    present_n0 = r.n0;
    presenting = 1'b1;
    req_valid = 1'b1;
    req_addr = AW'(a);
  endtask

  // reference model, memory model and request driver, all on the falling edge
  always @(negedge clk) begin
    if (running) begin
      bit exp_rdy, exp_rsp, exp_mreq;
      int edata, emaddr;
      string rtag;
      n++;
      exp_rdy = 1'b1; exp_rsp = 1'b0; exp_mreq = 1'b0;
      edata = 0; emaddr = 0; rtag = "R4 rsp_valid";
      foreach (recs[i]) begin
        if (recs[i].cnt_at == n) begin
          if (recs[i].hit) exp_hits++;
          else exp_misses++;
        end
        if (n >= recs[i].n0 && n <= recs[i].resp_at) exp_rdy = 1'b0;
        if (recs[i].resp_at == n) begin
          exp_rsp = 1'b1;
          edata = recs[i].data;
          rtag = recs[i].hit ? "R4 rsp_valid" : "R6 rsp_valid";
        end
        if (recs[i].mreq_at == n) begin
          exp_mreq = 1'b1;
          emaddr = recs[i].maddr;
        end
      end
      check("R7 req_ready", req_ready, exp_rdy);
      check(rtag, rsp_valid, exp_rsp);
      if (exp_rsp) check("R1 rsp_data", rsp_data, edata);
      check("R5 mem_req", mem_req, exp_mreq);
      if (exp_mreq) check("R5 mem_addr", mem_addr, emaddr);
      check("R8 hit_count", hit_count, exp_hits);
      check("R8 miss_count", miss_count, exp_misses);

      mem_rvalid = 1'b0;
      if (st_time.size() > 0 && st_time[0] == n) begin
        mem_rvalid = 1'b1;
        mem_rdata = WW'(word_of(st_addr[0]));
        void'(st_time.pop_front());
        void'(st_addr.pop_front());
      end
      if (mem_req) begin
        for (int k = 0; k < WPL; k++) begin
          st_time.push_back(n + MEM_FIRST + MEM_NEXT * k);
          st_addr.push_back(int'(mem_addr) / WB + k);
        end
      end

      if (presenting && n == present_n0) begin
        presenting = 1'b0;
        req_valid = 1'b0;
      end
      if (!presenting && stim.size() > 0) present(stim.pop_front());
      while (recs.size() > 0 && recs[0].resp_at < n) void'(recs.pop_front());
    end
  end

  task automatic wait_idle();
    do begin
      @(negedge clk);
      #1;
    end while (!(stim.size() == 0 && !presenting && recs.size() == 0));
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    int h0, m0;
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_addr = '0;
    mem_rvalid = 1'b0;
    mem_rdata = '0;
    for (int i = 0; i < NL; i++) begin
      mval[i] = 1'b0;
      mtag[i] = 0;
    end
    repeat (3) @(negedge clk);
    #1;
    // R3 reset state
    check("R3 rsp_valid in reset", rsp_valid, 0);
    check("R3 mem_req in reset", mem_req, 0);
    check("R3 hit_count in reset", hit_count, 0);
    check("R3 miss_count in reset", miss_count, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    @(posedge clk);
    #1;
    running = 1'b1;

    // R9 and R3: sequence from an empty cache
    stim = '{1, 13, 0, 6, 5, 6, 10, 12};
    wait_idle();
    check("R9 hits after load sequence", hit_count, 2);
    check("R9 misses after load sequence", miss_count, 6);

    // R10: same index, alternating tags
    h0 = hit_count; m0 = miss_count;
    stim = '{9, 1, 9, 1, 9, 1};
    wait_idle();
    check("R10 conflict misses", miss_count - m0, 6);
    check("R10 conflict hits", hit_count - h0, 0);

    // R1 and R2: sequential sweep, one miss then one hit per line
    h0 = hit_count; m0 = miss_count;
    for (int a = 16; a < 32; a++) stim.push_back(a);
    wait_idle();
    check("R2 sweep hits", hit_count - h0, 8);
    check("R1 sweep misses", miss_count - m0, 8);

    // R2 and R6: resident line keeps hitting, refilled line hits
    h0 = hit_count; m0 = miss_count;
    stim = '{31, 30, 31, 3, 2};
    wait_idle();
    check("R6 hits after refill", hit_count - h0, 4);
    check("R2 misses on resident reuse", miss_count - m0, 1);

    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

endmodule